// File: doc/BRIEF.md
# Address-Decoded NAND Bus Sequencer

This block lets a host drive a raw 8-bit NAND flash device by ordinary reads and writes into a memory window. The host address decides what kind of bus cycle each access becomes. Two address bits raise the address-latch and command-latch lines. A third bit picks which of two chip enables is driven low. A fourth bit redirects a read to a one-word status view of the shared ready/busy line. The host sends command and address bytes itself by writing to the matching window. The sequencer only produces correctly timed strobes; it does not interpret NAND commands.

A host access of one, two or four bytes becomes that many byte-wide NAND cycles, run back to back. Each cycle has a setup phase, a strobe phase and a hold phase. Their lengths come from a timing word, with separate values for reads and for writes. After the last byte a turnaround gap follows, with all chip enables released. The host is held off with a valid/ready handshake until the whole access and the gap are over. Read bytes are gathered little-endian into the host data word.

Top module: `nand_strobe_port`

## Requirements
- R1: After reset both chip enables, the write strobe and the read strobe are high, ALE, CLE and the data output enable are low, and host_ready is low.
- R2: Host address bit 3 drives ALE high and bit 4 drives CLE high for every byte cycle of the access; the two are independent, and with both clear the cycle is a plain data cycle.
- R3: Host address bit 12 set selects chip enable 1 (nand_ce_n[1] low), clear selects chip enable 0; at most one chip enable is ever low.
- R4: host_size 0 gives one byte cycle, 1 gives two, 2 or 3 gives four. Write byte k is host_wdata[8k+7:8k], sent in ascending k. Host address bits 1:0 have no effect.
- R5: On a read, byte k is placed in host_rdata[8k+7:8k], and lanes beyond the access size read as zero. Each byte is sampled on the last clock of its read strobe phase.
- R6: Each phase lasts its field value plus one clock. Timing word fields: write setup [29:26], write strobe [25:20], write hold [19:17], read setup [16:13], read strobe [12:7], read hold [6:4], turnaround [3:2]. The write or read strobe is low only in the strobe phase, and the two are never low together.
- R7: The selected chip enable stays low continuously from the first setup phase to the last hold phase, and is high during the turnaround gap.
- R8: host_ready rises, for the one completing clock, N*(S+T+H+3)+TA+1 clocks after the accepting edge, where N is the byte count and S, T, H are the fields of the access direction. TA is the turnaround field.
- R9: A read with host address bit 13 set completes in the cycle it is presented. It returns the ready/busy input, after a two-flop synchronizer, in bit 0 and zero elsewhere, and causes no NAND strobe. A write with bit 13 set completes at once and causes no strobe.
- R10: ALE, CLE and the data output hold still through the strobe and hold phases of a byte; the data output enable is high only for write accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_timing | input | 32 | Timing word, held stable during an access |
| host_valid | input | 1 | Host request present; held until host_ready |
| host_ready | output | 1 | Access complete in this cycle |
| host_write | input | 1 | 1 for write, 0 for read |
| host_size | input | 2 | 0 byte, 1 half word, 2/3 word |
| host_addr | input | 16 | Host byte address |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid with host_ready |
| nand_ce_n | output | 2 | Chip enables, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Data to the device |
| nand_dq_oe | output | 1 | Data bus drive enable |
| nand_dq_i | input | 8 | Data from the device |
| nand_rb | input | 1 | Wired-AND ready/busy, 1 = ready |

## Verification
On every cycle, the assertions check these properties: at most one chip enable low, the two strobes never overlapping, a strobe only inside an asserted chip enable, and latch lines and data held still across strobe and hold. They also check that chip enables are released when the host is released, and that phase counters stay in range. Only the bench's sweeps can show the actual timing and data. These are the phase lengths read from each field position, the total latency, the byte order on the bus, and the lane placement of read data. They also cover the independence from the low address bits, the synchronizer delay of the status bit, and the absence of strobes on status accesses.

// File: rtl/nand_seq_pkg.sv
// Shared types for the NAND strobe sequencer: phase encoding, decoded
// timing fields and the bit positions of those fields in the timing word.
package nand_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SETUP  = 3'd1,
        PH_STROBE = 3'd2,
        PH_HOLD   = 3'd3,
        PH_TURN   = 3'd4
    } phase_e;

    localparam int SU_W  = 4;
    localparam int ST_W  = 6;
    localparam int HD_W  = 3;
    localparam int TA_W  = 2;

    localparam int WSU_LSB = 26;
    localparam int WST_LSB = 20;
    localparam int WHD_LSB = 17;
    localparam int RSU_LSB = 13;
    localparam int RST_LSB = 7;
    localparam int RHD_LSB = 4;
    localparam int TA_LSB  = 2;

    typedef struct packed {
        logic [SU_W-1:0] wr_setup;
        logic [ST_W-1:0] wr_strobe;
        logic [HD_W-1:0] wr_hold;
        logic [SU_W-1:0] rd_setup;
        logic [ST_W-1:0] rd_strobe;
        logic [HD_W-1:0] rd_hold;
        logic [TA_W-1:0] turn;
    } timing_t;

endpackage

// File: rtl/nand_timing_decode.sv
// Splits the 32-bit timing word into its phase-count fields.
// Assumes the word is stable while an access is in flight; bits 31:30
// and the bus-width field in 1:0 carry no function (8-bit bus only).
module nand_timing_decode
    import nand_seq_pkg::*;
(
    input  logic [31:0] cfg,
    output timing_t     tim
);

    logic unused_cfg;

    // Field extraction at the fixed positions.
    always_comb begin
        tim.wr_setup  = cfg[WSU_LSB +: SU_W];
        tim.wr_strobe = cfg[WST_LSB +: ST_W];
        tim.wr_hold   = cfg[WHD_LSB +: HD_W];
        tim.rd_setup  = cfg[RSU_LSB +: SU_W];
        tim.rd_strobe = cfg[RST_LSB +: ST_W];
        tim.rd_hold   = cfg[RHD_LSB +: HD_W];
        tim.turn      = cfg[TA_LSB  +: TA_W];
    end

    assign unused_cfg = ^{cfg[31:30], cfg[1:0]};

endmodule

// File: rtl/nand_addr_decode.sv
// Decodes a host address and size into the cycle kind (ALE, CLE), chip
// select, status-window hit and the index of the last byte cycle.
// Assumes the address is held stable while host_valid is high.
module nand_addr_decode #(
    parameter int ADDR_W   = 16,
    parameter int ALE_BIT  = 3,
    parameter int CLE_BIT  = 4,
    parameter int CS_BIT   = 12,
    parameter int STAT_BIT = 13,
    parameter int BIDX_W   = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output logic              ale,
    output logic              cle,
    output logic              cs_sel,
    output logic              is_status,
    output logic [BIDX_W-1:0] last_idx
);

    localparam logic [BIDX_W-1:0] MAX_IDX = '1;

    logic unused_addr;

    // Address-bit decode of the cycle type and target.
    always_comb begin
        ale       = addr[ALE_BIT];
        cle       = addr[CLE_BIT];
        cs_sel    = addr[CS_BIT];
        is_status = addr[STAT_BIT];
    end

    // Size code to last byte index: 0 -> 0, 1 -> 1, others -> full word.
    always_comb begin
        unique case (size)
            2'd0:    last_idx = '0;
            2'd1:    last_idx = BIDX_W'(1);
            default: last_idx = MAX_IDX;
        endcase
    end

    assign unused_addr = ^addr;

endmodule

// File: rtl/nand_phase_engine.sv
// Runs setup/strobe/hold for each byte of an access, then the
// turnaround gap. Each phase lasts its count plus one clock.
// Assumes start is only raised while the engine is idle.
module nand_phase_engine
    import nand_seq_pkg::*;
#(
    parameter int BIDX_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wr,
    input  logic [BIDX_W-1:0] last_idx,
    input  timing_t           tim,
    output phase_e            phase,
    output logic [BIDX_W-1:0] bidx,
    output logic              done,
    output logic              sample
);

    localparam int CNT_W = ST_W;

    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  lim;
    logic [BIDX_W-1:0] last_q;
    logic              at_lim;

    // Count limit of the current phase for the current direction.
    always_comb begin
        unique case (phase)
            PH_SETUP:  lim = wr ? CNT_W'(tim.wr_setup)  : CNT_W'(tim.rd_setup);
            PH_STROBE: lim = wr ? CNT_W'(tim.wr_strobe) : CNT_W'(tim.rd_strobe);
            PH_HOLD:   lim = wr ? CNT_W'(tim.wr_hold)   : CNT_W'(tim.rd_hold);
            PH_TURN:   lim = CNT_W'(tim.turn);
            default:   lim = '0;
        endcase
    end

    assign at_lim = (cnt == lim);
    assign done   = (phase == PH_TURN) && at_lim;
    assign sample = (phase == PH_STROBE) && at_lim && !wr;

    // Phase, counter and byte-index sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            bidx   <= '0;
            last_q <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase  <= PH_SETUP;
                        cnt    <= '0;
                        bidx   <= '0;
                        last_q <= last_idx;
                    end
                end
                PH_SETUP: begin
                    if (at_lim) begin
                        phase <= PH_STROBE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_STROBE: begin
                    if (at_lim) begin
                        phase <= PH_HOLD;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (at_lim) begin
                        cnt <= '0;
                        if (bidx == last_q) begin
                            phase <= PH_TURN;
                        end else begin
                            phase <= PH_SETUP;
                            bidx  <= bidx + 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_TURN: begin
                    if (at_lim) begin
                        phase <= PH_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE) |-> (cnt <= lim)); // R6
    AST_BYTE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE) |-> (bidx <= last_q)); // R4

endmodule

// File: rtl/nand_strobe_port.sv
// Memory-mapped NAND port: turns host accesses into timed byte cycles on
// an 8-bit asynchronous NAND bus, with address-bit decode of ALE, CLE,
// chip select and a status window. Assumes host request fields stay
// stable while host_valid is high and cfg_timing is stable mid-access.
module nand_strobe_port
    import nand_seq_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int HOST_W   = 32,
    parameter int ALE_BIT  = 3,
    parameter int CLE_BIT  = 4,
    parameter int CS_BIT   = 12,
    parameter int STAT_BIT = 13,
    parameter int SYNC_LEN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       cfg_timing,
    input  logic              host_valid,
    output logic              host_ready,
    input  logic              host_write,
    input  logic [1:0]        host_size,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [HOST_W-1:0] host_wdata,
    output logic [HOST_W-1:0] host_rdata,
    output logic [1:0]        nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic [7:0]        nand_dq_o,
    output logic              nand_dq_oe,
    input  logic [7:0]        nand_dq_i,
    input  logic              nand_rb
);

    localparam int LANES  = HOST_W / 8;
    localparam int BIDX_W = $clog2(LANES);
    localparam int N_CE   = 2;

    timing_t             tim;
    phase_e              phase;
    logic [BIDX_W-1:0]   bidx;
    logic [BIDX_W-1:0]   dec_last;
    logic                dec_ale, dec_cle, dec_cs, dec_status;
    logic                done, sample, accept, status_hit, byte_act;
    logic                lat_wr, lat_ale, lat_cle, lat_cs;
    logic [HOST_W-1:0]   lat_wdata;
    logic [7:0]          rd_lane [LANES];
    logic [HOST_W-1:0]   rd_word;
    logic [SYNC_LEN-1:0] rb_sync;

    nand_timing_decode u_tdec (
        .cfg (cfg_timing),
        .tim (tim)
    );

    nand_addr_decode #(
        .ADDR_W   (ADDR_W),
        .ALE_BIT  (ALE_BIT),
        .CLE_BIT  (CLE_BIT),
        .CS_BIT   (CS_BIT),
        .STAT_BIT (STAT_BIT),
        .BIDX_W   (BIDX_W)
    ) u_adec (
        .addr      (host_addr),
        .size      (host_size),
        .ale       (dec_ale),
        .cle       (dec_cle),
        .cs_sel    (dec_cs),
        .is_status (dec_status),
        .last_idx  (dec_last)
    );

    assign status_hit = (phase == PH_IDLE) && host_valid && dec_status;
    assign accept     = (phase == PH_IDLE) && host_valid && !dec_status;
    assign byte_act   = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);

    nand_phase_engine #(
        .BIDX_W (BIDX_W)
    ) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .wr       (lat_wr),
        .last_idx (dec_last),
        .tim      (tim),
        .phase    (phase),
        .bidx     (bidx),
        .done     (done),
        .sample   (sample)
    );

    // Capture the request attributes at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_wr    <= 1'b0;
            lat_ale   <= 1'b0;
            lat_cle   <= 1'b0;
            lat_cs    <= 1'b0;
            lat_wdata <= '0;
        end else if (accept) begin
            lat_wr    <= host_write;
            lat_ale   <= dec_ale;
            lat_cle   <= dec_cle;
            lat_cs    <= dec_cs;
            lat_wdata <= host_wdata;
        end
    end

    // Ready/busy synchronizer.
    always_ff @(posedge clk) begin
        if (!rst_n) rb_sync <= '0;
        else        rb_sync <= {rb_sync[SYNC_LEN-2:0], nand_rb};
    end

    // One capture register per read byte lane.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n || accept)                         rd_lane[k] <= '0;
            else if (sample && (bidx == BIDX_W'(k)))      rd_lane[k] <= nand_dq_i;
        end
        assign rd_word[8*k +: 8] = rd_lane[k];
    end

    // One active-low enable per die, low only for the selected one.
    for (genvar c = 0; c < N_CE; c++) begin : g_ce
        assign nand_ce_n[c] = !(byte_act && (lat_cs == c[0]));
    end

    // Bus pin drive from the current phase.
    always_comb begin
        nand_ale   = byte_act && lat_ale;
        nand_cle   = byte_act && lat_cle;
        nand_we_n  = !((phase == PH_STROBE) && lat_wr);
        nand_re_n  = !((phase == PH_STROBE) && !lat_wr);
        nand_dq_oe = byte_act && lat_wr;
        nand_dq_o  = lat_wdata[{bidx, 3'b000} +: 8];
    end

    // Host completion and read data.
    always_comb begin
        host_ready = done || status_hit;
        host_rdata = status_hit ? {{(HOST_W-1){1'b0}}, rb_sync[SYNC_LEN-1]} : rd_word;
    end

    AST_ONE_CE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~nand_ce_n)); // R3
    AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n)); // R6
    AST_STROBE_IN_CE: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n || !nand_re_n) |-> (nand_ce_n != 2'b11)); // R7
    AST_PINS_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_STROBE) || (phase == PH_HOLD)) |->
        ($stable(nand_ale) && $stable(nand_cle) && $stable(nand_dq_o))); // R10
    AST_OE_NOT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n |-> !nand_dq_oe); // R10
    AST_CE_OFF_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |-> (nand_ce_n == 2'b11)); // R7

endmodule

// File: tb/test_nand_strobe_port.sv
// Sweeps direction, size, cycle kind, chip select and low address bits
// over three timing words; a bus monitor checks every strobe.
module test_nand_strobe_port;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_timing = '0;
    logic        host_valid = 1'b0;
    logic        host_ready;
    logic        host_write = 1'b0;
    logic [1:0]  host_size = '0;
    logic [15:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic [1:0]  nand_ce_n;
    logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [7:0]  nand_dq_o, nand_dq_i;
    logic        nand_rb = 1'b1;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    // Monitor state and expectations for the access in flight.
    bit          mon_on = 0;
    int          lowc = 0, ce_cyc = 0, sidx = 0, rd_total = 0;
    bit          exp_wr, exp_ale, exp_cle;
    logic [1:0]  exp_ce;
    int          exp_t;
    logic [31:0] exp_wdata;

    int ws, wst, wh, rs, rst, rh, ta;

    always #(CLK_PERIOD/2) clk = ~clk;

    nand_strobe_port i_nand_strobe_port (
        .clk(clk), .rst_n(rst_n), .cfg_timing(cfg_timing),
        .host_valid(host_valid), .host_ready(host_ready), .host_write(host_write),
        .host_size(host_size), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
        .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
        .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i),
        .nand_rb(nand_rb)
    );

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37) + 8'h5A);
    endfunction

    assign nand_dq_i = pat(rd_total);

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Count strobe-low and chip-enable-low cycles.
    always @(negedge clk) if (mon_on) begin
        if (!nand_we_n || !nand_re_n) lowc++;
        if (nand_ce_n != 2'b11) ce_cyc++;
    end

    // Check each byte cycle at the end of its strobe.
    always @(posedge nand_we_n or posedge nand_re_n) if (mon_on) begin
        check(lowc == exp_t + 1, "R6 strobe width", lowc, exp_t + 1);
        check(nand_ale == exp_ale, "R2 ale", nand_ale, exp_ale);
        check(nand_cle == exp_cle, "R2 cle", nand_cle, exp_cle);
        check(nand_ce_n == exp_ce, "R3 chip enable", nand_ce_n, exp_ce);
        if (exp_wr) begin
            check(nand_dq_o == 8'(exp_wdata >> (8*sidx)), "R4 write byte", nand_dq_o, 8'(exp_wdata >> (8*sidx)));
            check(nand_dq_oe == 1'b1, "R10 oe on write", nand_dq_oe, 1);
        end else begin
            check(nand_dq_oe == 1'b0, "R10 oe off on read", nand_dq_oe, 0);
            rd_total++;
        end
        sidx++;
        lowc = 0;
    end

    function automatic logic [31:0] make_cfg();
        return (32'(ws) << 26) | (32'(wst) << 20) | (32'(wh) << 17) |
               (32'(rs) << 13) | (32'(rst) << 7) | (32'(rh) << 4) | (32'(ta) << 2);
    endfunction

    task automatic run_access(input bit wr, input logic [1:0] sz, input logic [1:0] kind,
                              input bit cs, input logic [1:0] lowb, input int acc);
        int n, cycles, per, rd_start;
        logic [31:0] got, expd;
        logic [1:0] ce_at_ready;
        n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        per = wr ? (ws + wst + wh + 3) : (rs + rst + rh + 3);
        exp_wr = wr; exp_ale = kind[0]; exp_cle = kind[1];
        exp_ce = cs ? 2'b01 : 2'b10;
        exp_t = wr ? wst : rst;
        exp_wdata = 32'h9E3779B9 * 32'(acc + 1) + 32'h1234;
        rd_start = rd_total;
        sidx = 0; ce_cyc = 0; lowc = 0;
        host_write = wr; host_size = sz; host_wdata = exp_wdata;
        host_addr = 16'(lowb) | (16'(kind[0]) << 3) | (16'(kind[1]) << 4) | (16'(cs) << 12);
        host_valid = 1'b1;
        #1;
        cycles = 0;
        while (!host_ready && cycles < 1000) begin
            @(negedge clk);
            cycles++;
        end
        got = host_rdata;
        ce_at_ready = nand_ce_n;
        @(posedge clk);
        #1 host_valid = 1'b0;
        @(negedge clk);
        check(cycles == n*per + ta + 1, "R8 latency", cycles, n*per + ta + 1);
        check(sidx == n, "R4 byte count", sidx, n);
        check(ce_cyc == n*per, "R7 enable span", ce_cyc, n*per);
        check(ce_at_ready == 2'b11, "R7 released at ready", ce_at_ready, 2'b11);
        if (!wr) begin
            expd = '0;
            for (int k = 0; k < n; k++) expd |= 32'(pat(rd_start + k)) << (8*k);
            check(got == expd, "R5 read lanes", got, expd);
        end
    endtask

    task automatic status_read(input logic exp_bit);
        host_write = 1'b0; host_addr = 16'h2000; host_valid = 1'b1;
        #1;
        check(host_ready == 1'b1, "R9 status immediate", host_ready, 1);
        check(host_rdata == {31'b0, exp_bit}, "R9 status value", host_rdata, {31'b0, exp_bit});
        @(posedge clk);
        #1 host_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        int acc = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(nand_ce_n == 2'b11, "R1 ce", nand_ce_n, 2'b11);
        check(nand_we_n && nand_re_n, "R1 strobes", {nand_we_n, nand_re_n}, 2'b11);
        check(!nand_ale && !nand_cle && !nand_dq_oe, "R1 ale cle oe",
              {nand_ale, nand_cle, nand_dq_oe}, 0);
        check(host_ready == 1'b0, "R1 ready", host_ready, 0);
        mon_on = 1;

        for (int c = 0; c < 3; c++) begin
            if (c == 0) begin ws = 1; wst = 3; wh = 1; rs = 0; rst = 3; rh = 0; ta = 3; end
            else if (c == 1) begin ws = 0; wst = 0; wh = 2; rs = 2; rst = 1; rh = 1; ta = 0; end
            else begin ws = 3; wst = 5; wh = 0; rs = 0; rst = 6; rh = 2; ta = 2; end
            cfg_timing = make_cfg() | 32'(c);  // bus-width bits vary, no effect
            for (int wr = 0; wr < 2; wr++)
                for (int sz = 0; sz < 4; sz++)
                    for (int kind = 0; kind < 4; kind++)
                        for (int cs = 0; cs < 2; cs++) begin
                            run_access(wr[0], 2'(sz), 2'(kind), cs[0], 2'(acc), acc);
                            acc++;
                        end
        end

        // Status window: synchronized ready/busy, no strobes.
        nand_rb = 1'b0;
        repeat (3) @(negedge clk);
        sidx = 0;
        status_read(1'b0);
        nand_rb = 1'b1;
        repeat (3) @(negedge clk);
        status_read(1'b1);
        host_write = 1'b1; host_addr = 16'h2018; host_valid = 1'b1;
        #1;
        check(host_ready == 1'b1, "R9 status write completes", host_ready, 1);
        @(posedge clk);
        #1 host_valid = 1'b0;
        repeat (4) @(negedge clk);
        check(sidx == 0, "R9 no strobe on status", sidx, 0);
        check(nand_ce_n == 2'b11, "R9 chip idle after status", nand_ce_n, 2'b11);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule